// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block holds two 16-bit data pointers for a small CPU datapath. One bit in an auxiliary control register chooses which pointer is active. Every pointer operation acts on the active pointer only. The operations are a byte-wise special-function-register (SFR) read and write of its low and high byte, a 16-bit load and a 16-bit increment. The active value is driven out combinationally, so the memory interface can use it for external data addressing and for indexed code fetch.

The auxiliary register lives at its own SFR address. Bits 1 and 2 cannot be written and always read as zero. Because of this, an increment of the register flips the select bit and stops any carry before it reaches the upper bits. Software can therefore swap pointers with one increment. Instruction decode and the memory bus are outside this block. The CPU presents one-cycle strobes for each operation.

Top module: `dptr_bank`

## Requirements
- R1: After reset both pointers are 0x0000 and the auxiliary register is 0x00, so pointer 0 is active and `ptr_out` reads 0x0000.
- R2: An SFR write to address 0x82 sets the low byte of the active pointer, and a write to 0x83 sets its high byte. Reads at these addresses return those bytes combinationally.
- R3: A `ptr_ld` strobe loads `ptr_ld_val` into the active pointer in full.
- R4: A `ptr_inc` strobe adds 1 to the full 16-bit active pointer, and 0xFFFF wraps to 0x0000.
- R5: Writes, loads and increments leave the pointer that is not selected unchanged.
- R6: Bit 0 of the auxiliary register (SFR address 0xA2) selects the pointer: 0 selects pointer 0 and 1 selects pointer 1. `ptr_out` shows the newly selected pointer in the cycle after the register changes.
- R7: Auxiliary bits 1 and 2 ignore writes and read as 0. Bits 0 and 3 to 7 read back as written.
- R8: An `aux_inc` strobe adds 1 to the read value of the auxiliary register. This toggles bit 0 and leaves bits 3 to 7 unchanged.
- R9: On the active pointer, an SFR byte write takes priority over a load, and a load takes priority over an increment. The lower-priority operation is dropped for that cycle. An SFR write to the auxiliary register takes priority over `aux_inc`.
- R10: A read at any other SFR address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational |
| ptr_ld | input | 1 | Load the active pointer with `ptr_ld_val` |
| ptr_ld_val | input | 16 | Value for a 16-bit load |
| ptr_inc | input | 1 | Increment the active pointer |
| aux_inc | input | 1 | Increment the auxiliary register |
| ptr_out | output | 16 | Active pointer value |

## Verification
Two pairs of operations can land in the same cycle: an SFR byte write and an increment (or load) of the active pointer, and an SFR write to the auxiliary register together with `aux_inc`. The bench raises both strobes in one cycle on purpose. It then checks that the written byte appears, the other byte is unchanged and no increment leaked in. It also checks that the auxiliary register holds the written value and not the incremented one. A further collision test changes the selection in the same cycle as a pointer increment, and confirms that the increment landed on the pointer that was selected before the change.

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter logic [7:0] LO_ADDR     = 8'h82,
  parameter logic [7:0] HI_ADDR     = 8'h83,
  parameter logic [7:0] AUX_ADDR    = 8'hA2,
  parameter logic [7:0] AUX_RO_MASK = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        ptr_ld,
  input  logic [15:0] ptr_ld_val,
  input  logic        ptr_inc,
  input  logic        aux_inc,
  output logic [15:0] ptr_out
);
  logic [15:0] dp0, dp1, nxt;
  logic [7:0]  aux_q;

  wire       sel    = aux_q[0];
  wire       lo_wr  = sfr_wr && (sfr_addr == LO_ADDR);
  wire       hi_wr  = sfr_wr && (sfr_addr == HI_ADDR);
  wire       aux_wr = sfr_wr && (sfr_addr == AUX_ADDR);
  wire [7:0] aux_rd = aux_q & ~AUX_RO_MASK;
  wire [7:0] aux_up = aux_rd + 8'd1;

  assign ptr_out = sel ? dp1 : dp0;

  always_comb begin
    nxt = ptr_out;
    if (lo_wr)        nxt[7:0]  = sfr_wdata;
    else if (hi_wr)   nxt[15:8] = sfr_wdata;
    else if (ptr_ld)  nxt       = ptr_ld_val;
    else if (ptr_inc) nxt       = ptr_out + 16'd1;
  end

  always_comb begin
    if (sfr_addr == LO_ADDR)       sfr_rdata = ptr_out[7:0];
    else if (sfr_addr == HI_ADDR)  sfr_rdata = ptr_out[15:8];
    else if (sfr_addr == AUX_ADDR) sfr_rdata = aux_rd;
    else                           sfr_rdata = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp0   <= '0;
      dp1   <= '0;
      aux_q <= '0;
    end else begin
      if (sel) dp1 <= nxt;
      else     dp0 <= nxt;
      if (aux_wr)       aux_q <= sfr_wdata & ~AUX_RO_MASK;
      else if (aux_inc) aux_q <= aux_up & ~AUX_RO_MASK;
    end
  end

  AST_UNSEL0_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> $stable(dp0)); // R5
  AST_UNSEL1_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(dp1)); // R5
  AST_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == AUX_ADDR) |-> ((sfr_rdata & AUX_RO_MASK) == 8'h00)); // R7
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_ld && !lo_wr && !hi_wr && !aux_wr && !aux_inc && ptr_out == 16'hFFFF)
    |=> (ptr_out == 16'h0000)); // R4
  AST_AUX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_inc && !aux_wr) |=> (sel != $past(sel))); // R8
  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && (ptr_inc || ptr_ld) && !aux_inc)
    |=> (ptr_out[7:0] == $past(sfr_wdata) && ptr_out[15:8] == $past(ptr_out[15:8]))); // R9
endmodule

// File: tb/tb_dptr_bank.sv
`timescale 1ns/1ps
module tb_dptr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr, ptr_ld, ptr_inc, aux_inc;
  logic [15:0] ptr_ld_val, ptr_out;
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [7:0] LO = 8'h82, HI = 8'h83, AUX = 8'hA2;

  always #2.5 clk = ~clk;

  dptr_bank dut (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_ld(ptr_ld),
    .ptr_ld_val(ptr_ld_val), .ptr_inc(ptr_inc), .aux_inc(aux_inc), .ptr_out(ptr_out));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sfr_wr = 0; ptr_ld = 0; ptr_inc = 0; aux_inc = 0;
    sfr_addr = 8'h00; sfr_wdata = 8'h00; ptr_ld_val = 16'h0000;
  endtask

  // one operation cycle: drive at negedge, strobe clears after the next posedge
  task automatic step();
    @(posedge clk); #1; idle(); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d; step();
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #1; d = sfr_rdata; sfr_addr = 8'h00;
  endtask

  task automatic load(logic [15:0] v);
    ptr_ld = 1; ptr_ld_val = v; step();
  endtask

  task automatic inc();
    ptr_inc = 1; step();
  endtask

  task automatic select(bit s);
    wr(AUX, {7'd0, s});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ptr_out", ptr_out, 16'h0000);
    rd(AUX, d); chk("R1 aux", {8'h0, d}, 16'h0000);
    select(1); chk("R1 ptr1 reset", ptr_out, 16'h0000);
    select(0);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    wr(LO, 8'h3C); wr(HI, 8'hA5);
    chk("R2 word", ptr_out, 16'hA53C);
    rd(LO, d); chk("R2 read lo", {8'h0, d}, 16'h003C);
    rd(HI, d); chk("R2 read hi", {8'h0, d}, 16'h00A5);
    rd(8'h81, d); chk("R10 unmapped", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_select_isolation();
    select(1);
    chk("R6 ptr1 selected", ptr_out, 16'h0000);
    load(16'h1234); inc(); wr(HI, 8'h77);
    chk("R3 R4 ptr1", ptr_out, 16'h7735);
    select(0);
    chk("R5 ptr0 untouched", ptr_out, 16'hA53C);
    load(16'hBEEF); inc();
    chk("R3 R4 ptr0", ptr_out, 16'hBEF0);
    select(1);
    chk("R5 ptr1 untouched", ptr_out, 16'h7735);
    select(0);
  endtask

  task automatic t_wrap();
    load(16'hFFFF); inc();
    chk("R4 wrap", ptr_out, 16'h0000);
    load(16'h00FF); inc();
    chk("R4 carry", ptr_out, 16'h0100);
  endtask

  task automatic t_aux();
    logic [7:0] d;
    wr(AUX, 8'hFF);
    rd(AUX, d); chk("R7 ro bits", {8'h0, d}, 16'h00F9);
    chk("R6 sel by bit0", ptr_out, 16'h7735);
    aux_inc = 1; step();
    rd(AUX, d); chk("R8 toggle off", {8'h0, d}, 16'h00F8);
    chk("R6 back to ptr0", ptr_out, 16'h0100);
    aux_inc = 1; step();
    rd(AUX, d); chk("R8 toggle on", {8'h0, d}, 16'h00F9);
    wr(AUX, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    load(16'h12FF);
    sfr_wr = 1; sfr_addr = LO; sfr_wdata = 8'h40; ptr_inc = 1; step();
    chk("R9 write beats inc", ptr_out, 16'h1240);
    sfr_wr = 1; sfr_addr = HI; sfr_wdata = 8'h99; ptr_ld = 1; ptr_ld_val = 16'h5555; step();
    chk("R9 write beats load", ptr_out, 16'h9940);
    ptr_ld = 1; ptr_ld_val = 16'h2000; ptr_inc = 1; step();
    chk("R9 load beats inc", ptr_out, 16'h2000);
    sfr_wr = 1; sfr_addr = AUX; sfr_wdata = 8'h10; aux_inc = 1; step();
    rd(AUX, d); chk("R9 aux write beats inc", {8'h0, d}, 16'h0010);
    aux_inc = 1; ptr_inc = 1; step();
    chk("R5 R6 inc hit old sel", ptr_out, 16'h7735);
    select(0);
    chk("R4 old ptr incremented", ptr_out, 16'h2001);
  endtask

  initial begin
    idle(); rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset(); t_bytes(); t_select_isolation(); t_wrap(); t_aux(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule